// File: doc/BRIEF.md
# Split-Cycle Asynchronous Bus Master

This block connects an internal requester to an external asynchronous bus that has a 16-bit data path. The requester asks for a byte, a 16-bit word or a 32-bit longword, either a read or a write, at a 24-bit byte address. The block turns each request into one or two handshaked bus cycles. A bus cycle drives a word address, a direction line and a pair of active-low byte-lane strobes. It then holds them until the addressed slave pulls the active-low acknowledge low. There is no address bit 0 on the bus. The strobes alone say which byte lane is used: the upper lane carries the even byte and the lower lane carries the odd byte.

A longword is split into two word cycles. The high-order half goes first, at the base address, and the low-order half follows at base+2. The acknowledge input is asynchronous, so it passes through a synchronizer chain. Each cycle releases its strobes once acknowledge has been seen. The next cycle, or the completion, waits until acknowledge has been seen released again. A programmable wait limit ends a cycle whose slave never answers. Read data comes back right-aligned and zero-extended, together with a one-cycle done pulse.

Top module: `split_bus_master`

## Requirements
- R1: While reset is held and on leaving it, both strobes are high (1), the direction line reads high (1 = read), and busy, done, address-error and bus-error are all low.
- R2: A byte access (size code 0) asserts only the upper strobe for an even address or only the lower strobe for an odd address. A byte write drives the data byte on both halves of the bus. A byte read returns bus bits 15:8 (even) or 7:0 (odd) in result bits 7:0, with the upper result bits zero.
- R3: A word access (size code 1, and code 3 treated the same) asserts both strobes at word address addr[23:1], moves bits 15:0 of the write data, and returns the read word in result bits 15:0 with bits 31:16 zero.
- R4: A longword access (size code 2) runs two word cycles. The first is at addr[23:1] carrying write bits 31:16, and the second is at addr[23:1]+1 carrying bits 15:0. The read result is {first word, second word}.
- R5: A word or longword request with address bit 0 set raises address-error together with done on the first edge after the request, and no strobe is asserted.
- R6: A cycle's strobes stay low until acknowledge, after two synchronizer stages, is seen low. Strobes are only low while busy. With the slave acknowledging D edges after the strobes fall, a single-cycle access completes D+5 edges after the request is taken.
- R7: After the strobes rise, neither the next half-cycle nor done comes before acknowledge has been seen high again. Each extra cycle that the slave holds acknowledge adds one cycle to the access.
- R8: If acknowledge is not seen within the wait limit (in clocks, counted from the strobes' falling edge), the strobes rise and bus-error pulses together with done exactly that many edges after the cycle began. An acknowledge seen on the same edge wins.
- R9: A request presented while busy is ignored: it starts no bus cycle and changes no data.
- R10: During one cycle, address, direction, write data and strobes are stable while any strobe is low. The direction line is high for reads and low for writes.
- R11: Done is high for exactly one clock per request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, taken when not busy |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | 0 byte, 1 word, 2 longword, 3 word |
| req_addr | input | 24 | Byte address |
| req_wdata | input | 32 | Write data, right-aligned |
| wait_limit | input | 16 | Clocks to wait for acknowledge before abort |
| busy | output | 1 | Access in progress |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 32 | Read result, valid with done |
| addr_err | output | 1 | Misaligned request, pulses with done |
| bus_err | output | 1 | Acknowledge timeout, pulses with done |
| bus_addr | output | 23 | Word address on the bus |
| uds_n | output | 1 | Upper (even) byte strobe, active low |
| lds_n | output | 1 | Lower (odd) byte strobe, active low |
| bus_rw | output | 1 | Direction, 1 read, 0 write |
| bus_dout | output | 16 | Write data to the bus |
| bus_din | input | 16 | Read data from the bus |
| dtack_n | input | 1 | Transfer acknowledge from the slave, active low |

## Verification
Every result has a fixed distance from the edge that takes the request. A misaligned request is done on that same edge. A word cycle whose slave answers D edges after the strobes fall is done D+5 edges later, plus any extra hold of acknowledge. A longword adds its two halves. A timeout is done exactly wait-limit edges after the strobes fall. The bench drives inputs and samples outputs on falling edges, and it counts those edges from the request to the first done. It compares the count with the value predicted from the slave's programmed delay. It also records every bus cycle when its strobes first fall, and compares the address, strobes, direction and data with a list computed from the request.

// File: rtl/sbm_pkg.sv
package sbm_pkg;
  localparam int BUS_W = 16;
  localparam int REQ_W = 32;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_WORD = 2'd1,
    SZ_LONG = 2'd2
  } xfer_size_t;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_STROBE  = 2'd1,
    ST_RELEASE = 2'd2
  } bus_state_t;
endpackage

// File: rtl/sbm_ack_sync.sv
module sbm_ack_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic ack_n_async,
  output logic ack_seen
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain[0] <= 1'b0;
    else     chain[0] <= ~ack_n_async;
  end

  generate
    for (genvar i = 1; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) chain[i] <= 1'b0;
        else     chain[i] <= chain[i-1];
      end
    end
  endgenerate

  assign ack_seen = chain[STAGES-1];
endmodule

// File: rtl/sbm_wait_timer.sv
module sbm_wait_timer #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clear,
  input  logic [TW-1:0] limit,
  output logic          expired
);
  logic [TW-1:0] cnt;
  logic [TW:0]   nxt;

  assign nxt     = {1'b0, cnt} + {{TW{1'b0}}, 1'b1};
  assign expired = nxt >= {1'b0, limit};

  always_ff @(posedge clk) begin
    if (rst || clear)   cnt <= '0;
    else if (cnt != '1) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/sbm_lane_steer.sv
module sbm_lane_steer
  import sbm_pkg::*;
(
  input  xfer_size_t        size,
  input  logic              addr0,
  input  logic              second,
  input  logic [REQ_W-1:0]  wdata,
  input  logic [BUS_W-1:0]  din,
  output logic              upper_n,
  output logic              lower_n,
  output logic [BUS_W-1:0]  dout,
  output logic [BUS_W-1:0]  piece
);
  localparam int HB = BUS_W / 2;

  always_comb begin
    if (size == SZ_BYTE) begin
      upper_n = addr0;
      lower_n = ~addr0;
      dout    = {2{wdata[HB-1:0]}};
      piece   = addr0 ? {{HB{1'b0}}, din[HB-1:0]} : {{HB{1'b0}}, din[BUS_W-1:HB]};
    end else begin
      upper_n = 1'b0;
      lower_n = 1'b0;
      dout    = (size == SZ_LONG && !second) ? wdata[REQ_W-1:BUS_W] : wdata[BUS_W-1:0];
      piece   = din;
    end
  end
endmodule

// File: rtl/split_bus_master.sv
module split_bus_master
  import sbm_pkg::*;
#(
  parameter int AW          = 24,
  parameter int TW          = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [1:0]        req_size,
  input  logic [AW-1:0]     req_addr,
  input  logic [REQ_W-1:0]  req_wdata,
  input  logic [TW-1:0]     wait_limit,
  output logic              busy,
  output logic              done,
  output logic [REQ_W-1:0]  rdata,
  output logic              addr_err,
  output logic              bus_err,
  output logic [AW-2:0]     bus_addr,
  output logic              uds_n,
  output logic              lds_n,
  output logic              bus_rw,
  output logic [BUS_W-1:0]  bus_dout,
  input  logic [BUS_W-1:0]  bus_din,
  input  logic              dtack_n
);
  localparam int WA = AW - 1;

  function automatic xfer_size_t to_size(input logic [1:0] code);
    case (code)
      2'd0:    return SZ_BYTE;
      2'd2:    return SZ_LONG;
      default: return SZ_WORD;
    endcase
  endfunction

  bus_state_t        state;
  xfer_size_t        size_q;
  logic              write_q, a0_q, second_q;
  logic [REQ_W-1:0]  wdata_q, rbuf;

  logic              ack_seen, expired;
  xfer_size_t        sz_in, st_size;
  logic              idle, misalign, st_a0, st_second;
  logic [REQ_W-1:0]  st_wdata;
  logic              st_upper_n, st_lower_n;
  logic [BUS_W-1:0]  st_dout, st_piece;

  assign idle      = (state == ST_IDLE);
  assign busy      = ~idle;
  assign sz_in     = to_size(req_size);
  assign misalign  = (sz_in != SZ_BYTE) && req_addr[0];
  assign st_size   = idle ? sz_in : size_q;
  assign st_a0     = idle ? req_addr[0] : a0_q;
  assign st_wdata  = idle ? req_wdata : wdata_q;
  assign st_second = (state == ST_RELEASE);

  sbm_ack_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk(clk), .rst(rst), .ack_n_async(dtack_n), .ack_seen(ack_seen)
  );

  sbm_wait_timer #(.TW(TW)) i_timer (
    .clk(clk), .rst(rst), .clear(state != ST_STROBE),
    .limit(wait_limit), .expired(expired)
  );

  sbm_lane_steer i_steer (
    .size(st_size), .addr0(st_a0), .second(st_second), .wdata(st_wdata),
    .din(bus_din), .upper_n(st_upper_n), .lower_n(st_lower_n),
    .dout(st_dout), .piece(st_piece)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      size_q   <= SZ_BYTE;
      write_q  <= 1'b0;
      a0_q     <= 1'b0;
      second_q <= 1'b0;
      wdata_q  <= '0;
      rbuf     <= '0;
      rdata    <= '0;
      done     <= 1'b0;
      addr_err <= 1'b0;
      bus_err  <= 1'b0;
      bus_addr <= '0;
      uds_n    <= 1'b1;
      lds_n    <= 1'b1;
      bus_rw   <= 1'b1;
      bus_dout <= '0;
    end else begin
      done     <= 1'b0;
      addr_err <= 1'b0;
      bus_err  <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (req_valid) begin
            if (misalign) begin
              done     <= 1'b1;
              addr_err <= 1'b1;
            end else begin
              size_q   <= sz_in;
              write_q  <= req_write;
              a0_q     <= req_addr[0];
              second_q <= 1'b0;
              wdata_q  <= req_wdata;
              rbuf     <= '0;
              bus_addr <= req_addr[AW-1:1];
              bus_rw   <= ~req_write;
              bus_dout <= st_dout;
              uds_n    <= st_upper_n;
              lds_n    <= st_lower_n;
              state    <= ST_STROBE;
            end
          end
        end
        ST_STROBE: begin
          if (ack_seen) begin
            uds_n <= 1'b1;
            lds_n <= 1'b1;
            if (!write_q)
              rbuf <= (size_q == SZ_LONG) ? {rbuf[BUS_W-1:0], st_piece}
                                          : {{(REQ_W-BUS_W){1'b0}}, st_piece};
            state <= ST_RELEASE;
          end else if (expired) begin
            uds_n   <= 1'b1;
            lds_n   <= 1'b1;
            done    <= 1'b1;
            bus_err <= 1'b1;
            state   <= ST_IDLE;
          end
        end
        ST_RELEASE: begin
          if (!ack_seen) begin
            if (size_q == SZ_LONG && !second_q) begin
              second_q <= 1'b1;
              bus_addr <= bus_addr + WA'(1);
              bus_dout <= st_dout;
              uds_n    <= st_upper_n;
              lds_n    <= st_lower_n;
              state    <= ST_STROBE;
            end else begin
              done <= 1'b1;
              if (!write_q) rdata <= rbuf;
              state <= ST_IDLE;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sbm_checker.sv
module sbm_checker #(
  parameter int AW = 24
) (
  input logic          clk,
  input logic          rst,
  input logic          busy,
  input logic          done,
  input logic          addr_err,
  input logic          bus_err,
  input logic          uds_n,
  input logic          lds_n,
  input logic          bus_rw,
  input logic [AW-2:0] bus_addr,
  input logic [15:0]   bus_dout
);
  logic strobing;
  assign strobing = ~uds_n | ~lds_n;

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R11

  AST_ADDR_ERR_QUIET: assert property (@(posedge clk) disable iff (rst)
    addr_err |-> (done && uds_n && lds_n && !bus_err)); // R5

  AST_TIMEOUT_ENDS: assert property (@(posedge clk) disable iff (rst)
    bus_err |-> (done && uds_n && lds_n && !busy)); // R8

  AST_STROBE_BUSY: assert property (@(posedge clk) disable iff (rst)
    strobing |-> busy); // R6

  AST_CYCLE_STABLE: assert property (@(posedge clk) disable iff (rst)
    strobing |=> (!strobing || ($stable(bus_addr) && $stable(bus_rw) &&
                  $stable(bus_dout) && $stable(uds_n) && $stable(lds_n)))); // R10
endmodule

bind split_bus_master sbm_checker #(.AW(AW)) i_sbm_checker (
  .clk(clk), .rst(rst), .busy(busy), .done(done), .addr_err(addr_err),
  .bus_err(bus_err), .uds_n(uds_n), .lds_n(lds_n), .bus_rw(bus_rw),
  .bus_addr(bus_addr), .bus_dout(bus_dout)
);

// File: tb/test_split_bus_master.sv
module test_split_bus_master;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [1:0]  req_size = 2'd0;
  logic [23:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic [15:0] wait_limit = 16'd16;
  logic        busy, done, addr_err, bus_err, uds_n, lds_n, bus_rw;
  logic [31:0] rdata;
  logic [22:0] bus_addr;
  logic [15:0] bus_dout, bus_din;
  logic        dtack_n = 1'b1;

  logic [15:0] mem [256];
  logic [41:0] mon_q [$];
  int d0_g = 1, d1_g = 1, hold_g = 0, cyc_no = 0, cur_d = 0, scnt = 0, hcnt = 0;
  bit in_cyc = 1'b0;
  int checks = 0, fails = 0;

  always #(CLK_P/2) clk = ~clk;

  split_bus_master i_split_bus_master (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_size(req_size), .req_addr(req_addr), .req_wdata(req_wdata),
    .wait_limit(wait_limit), .busy(busy), .done(done), .rdata(rdata),
    .addr_err(addr_err), .bus_err(bus_err), .bus_addr(bus_addr),
    .uds_n(uds_n), .lds_n(lds_n), .bus_rw(bus_rw), .bus_dout(bus_dout),
    .bus_din(bus_din), .dtack_n(dtack_n)
  );

  assign bus_din = mem[bus_addr[7:0]];

  // slave model: answers cur_d falling edges after the strobes fall
  always @(negedge clk) begin
    if (rst) begin
      dtack_n <= 1'b1;
      in_cyc = 1'b0;
    end else if (!uds_n || !lds_n) begin
      if (!in_cyc) begin
        in_cyc = 1'b1;
        scnt = 0;
        mon_q.push_back({bus_addr, uds_n, lds_n, bus_rw, bus_dout});
        cur_d = (cyc_no == 0) ? d0_g : d1_g;
        cyc_no++;
      end
      scnt++;
      if (cur_d != 0 && scnt == cur_d) begin
        dtack_n <= 1'b0;
        if (!bus_rw) begin
          if (!uds_n) mem[bus_addr[7:0]][15:8] = bus_dout[15:8];
          if (!lds_n) mem[bus_addr[7:0]][7:0]  = bus_dout[7:0];
        end
      end
    end else begin
      if (in_cyc) begin
        in_cyc = 1'b0;
        hcnt = 0;
      end
      if (dtack_n == 1'b0) begin
        hcnt++;
        if (hcnt > hold_g) dtack_n <= 1'b1;
      end
    end
  end

  task automatic chk(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", rq, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_read(input logic [1:0] sz, input logic [23:0] a);
    logic [15:0] w0, w1;
    w0 = mem[a[8:1]];
    w1 = mem[8'(a[8:1] + 8'd1)];
    if (sz == 2'd0) return a[0] ? {24'h0, w0[7:0]} : {24'h0, w0[15:8]};
    if (sz == 2'd2) return {w0, w1};
    return {16'h0, w0};
  endfunction

  task automatic access(input bit w, input logic [1:0] sz, input logic [23:0] a,
                        input logic [31:0] wd, input int d0, input int d1, input int h,
                        input int lim, input int exp_lat, input int exp_ncyc,
                        input bit exp_be, input bit exp_ae, input logic [31:0] exp_rd,
                        input string rq, input bit poke);
    int idx, got;
    d0_g = d0; d1_g = d1; hold_g = h; cyc_no = 0;
    mon_q.delete();
    @(negedge clk);
    req_valid = 1'b1; req_write = w; req_size = sz; req_addr = a;
    req_wdata = wd; wait_limit = lim[15:0];
    @(negedge clk);
    req_valid = 1'b0;
    idx = 0; got = -1;
    while (idx < 300) begin
      if (poke && idx == 2) begin
        req_valid = 1'b1; req_write = 1'b1; req_size = 2'd0;
        req_addr = 24'h40; req_wdata = 32'hFF;
      end
      if (poke && idx == 3) req_valid = 1'b0;
      if (done) begin
        got = idx;
        break;
      end
      @(negedge clk);
      idx++;
    end
    chk(got == exp_lat, {rq, " done latency"}, 64'(got), 64'(exp_lat));
    chk(bus_err == exp_be, {rq, " bus_err"}, 64'(bus_err), 64'(exp_be));
    chk(addr_err == exp_ae, {rq, " addr_err"}, 64'(addr_err), 64'(exp_ae));
    if (!w && !exp_be && !exp_ae)
      chk(rdata == exp_rd, {rq, " rdata"}, 64'(rdata), 64'(exp_rd));
    chk(mon_q.size() == exp_ncyc, {rq, " bus cycle count"}, 64'(mon_q.size()), 64'(exp_ncyc));
    for (int k = 0; k < mon_q.size() && k < exp_ncyc; k++) begin
      logic [41:0] e;
      logic [22:0] ea;
      logic        eu, el;
      logic [15:0] ed;
      e  = mon_q[k];
      ea = a[23:1] + 23'(k);
      eu = (sz == 2'd0) ? a[0] : 1'b0;
      el = (sz == 2'd0) ? ~a[0] : 1'b0;
      if (sz == 2'd0)      ed = {2{wd[7:0]}};
      else if (sz == 2'd2) ed = (k == 0) ? wd[31:16] : wd[15:0];
      else                 ed = wd[15:0];
      chk(e[41:19] == ea, {rq, " bus address"}, 64'(e[41:19]), 64'(ea));
      chk(e[18:17] == {eu, el}, {rq, " strobes"}, 64'(e[18:17]), 64'({eu, el}));
      chk(e[16] == ~w, {rq, " R10 direction"}, 64'(e[16]), 64'(~w));
      if (w) chk(e[15:0] == ed, {rq, " write data"}, 64'(e[15:0]), 64'(ed));
    end
    @(negedge clk);
    chk(done == 1'b0, {rq, " R11 done single cycle"}, 64'(done), 64'd0);
    repeat (6) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog act=%0d exp=%0d", checks, 0);
    $display("test done: total=%0d bad=%0d", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 16'(i * 16'h0101) ^ 16'h5A3C;
    repeat (4) @(negedge clk);
    chk(uds_n && lds_n, "R1 strobes high in reset", 64'({uds_n, lds_n}), 64'h3);
    rst = 1'b0;
    @(negedge clk);
    chk(uds_n && lds_n && bus_rw, "R1 bus idle after reset", 64'({uds_n, lds_n, bus_rw}), 64'h7);
    chk(!busy && !done && !addr_err && !bus_err, "R1 status low after reset",
        64'({busy, done, addr_err, bus_err}), 64'h0);

    // R3 R6: word read, slave delay 2 -> 7
    access(0, 2'd1, 24'h000010, 0, 2, 0, 0, 16, 7, 1, 0, 0, exp_read(2'd1, 24'h10), "R3 R6 word read", 0);
    // R2: byte reads, even and odd lanes
    access(0, 2'd0, 24'h000020, 0, 1, 0, 0, 16, 6, 1, 0, 0, exp_read(2'd0, 24'h20), "R2 even byte read", 0);
    access(0, 2'd0, 24'h000021, 0, 3, 0, 0, 16, 8, 1, 0, 0, exp_read(2'd0, 24'h21), "R2 odd byte read", 0);
    // R3 size code 3 behaves as word
    access(0, 2'd3, 24'h000012, 0, 1, 0, 0, 16, 6, 1, 0, 0, exp_read(2'd1, 24'h12), "R3 size3 read", 0);
    // R3 R10: word write then read back
    access(1, 2'd1, 24'h000030, 32'h0000BEEF, 2, 0, 0, 16, 7, 1, 0, 0, 0, "R3 R10 word write", 0);
    access(0, 2'd1, 24'h000030, 0, 1, 0, 0, 16, 6, 1, 0, 0, 32'h0000BEEF, "R3 word readback", 0);
    // R2: byte writes on each lane
    access(1, 2'd0, 24'h000031, 32'h000000A5, 1, 0, 0, 16, 6, 1, 0, 0, 0, "R2 odd byte write", 0);
    access(1, 2'd0, 24'h000030, 32'h00000011, 2, 0, 0, 16, 7, 1, 0, 0, 0, "R2 even byte write", 0);
    access(0, 2'd1, 24'h000030, 0, 1, 0, 0, 16, 6, 1, 0, 0, 32'h000011A5, "R2 byte lanes readback", 0);
    // R4: longword write and read, high word first
    access(1, 2'd2, 24'h000040, 32'h12345678, 1, 3, 0, 16, 14, 2, 0, 0, 0, "R4 long write", 0);
    access(0, 2'd2, 24'h000040, 0, 2, 2, 0, 16, 14, 2, 0, 0, 32'h12345678, "R4 long read", 0);
    // R7: slave holds acknowledge 2 extra cycles on each half
    access(0, 2'd2, 24'h000040, 0, 1, 1, 2, 16, 16, 2, 0, 0, 32'h12345678, "R7 long read held ack", 0);
    access(0, 2'd1, 24'h000010, 0, 2, 0, 3, 16, 10, 1, 0, 0, exp_read(2'd1, 24'h10), "R7 word held ack", 0);
    // R5: misaligned word and longword
    access(0, 2'd1, 24'h000011, 0, 1, 0, 0, 16, 0, 0, 0, 1, 0, "R5 misaligned word", 0);
    access(1, 2'd2, 24'h000043, 32'hDEADBEEF, 1, 1, 0, 16, 0, 0, 0, 1, 0, "R5 misaligned long", 0);
    // R8: timeouts and the boundary
    access(0, 2'd1, 24'h000010, 0, 0, 0, 0, 5, 5, 1, 1, 0, 0, "R8 no answer", 0);
    access(0, 2'd1, 24'h000010, 0, 3, 0, 0, 4, 4, 1, 1, 0, 0, "R8 limit one short", 0);
    access(0, 2'd1, 24'h000010, 0, 3, 0, 0, 5, 8, 1, 0, 0, exp_read(2'd1, 24'h10), "R8 limit just met", 0);
    access(0, 2'd2, 24'h000040, 0, 2, 0, 0, 6, 13, 2, 1, 0, 0, "R8 second half timeout", 0);
    // R9: request while busy is ignored; longword at 0x40 stays intact
    access(1, 2'd1, 24'h000050, 32'h00003C3C, 2, 0, 0, 16, 7, 1, 0, 0, 0, "R9 busy poke", 1);
    access(0, 2'd2, 24'h000040, 0, 1, 1, 0, 16, 12, 2, 0, 0, 32'h12345678, "R9 data untouched", 0);

    $display("test done: total=%0d bad=%0d", checks, fails);
    $finish;
  end
endmodule